// File: doc/BRIEF.md
# Three-Slot Instruction Issue Aligner

This block sits between instruction fetch and decode. Each cycle it looks at a small window of fetched instructions, oldest first, and each instruction carries a class mark saying whether it is a data operation or a control operation (jump, call, return, control-stack manipulation). It forms one issue group of up to three instructions and places them into three decode lanes: two data lanes and a control lane. The lanes fill in the fixed order data lane 1, data lane 2, control lane, and any lane may be left empty in a group. Later instructions are shifted into the right lane, so nothing goes to a lane that does not suit its class.

The group is registered into the issue outputs at the clock edge. The count of instructions taken is given back to fetch in the same cycle, so fetch can advance its window. While the downstream stall is high nothing is taken and the issue outputs keep their values. Separately, condition status from the two data pipelines is registered and passed to the control lane. This status is the only link between the data lanes and the control lane.

Top module: `issue_aligner`

## Requirements
- R1: While reset (rst_n low) is sampled at a clock edge, all three lane-valid outputs, all lane words and the forwarded status become zero.
- R2: A window of data, data, control (class bit 0 = data, 1 = control; lane 0 of the window is the oldest, word i at bits [i*IW +: IW]) reports consumed 3 and after the edge fills data lane 1, data lane 2 and the control lane in that order.
- R3: Data instructions go to the data lanes in window order: the first taken goes to data lane 1 and the second to data lane 2.
- R4: A control instruction never reaches a data lane, and it closes the group: a data instruction after it in the window is not taken in the same group.
- R5: A data instruction followed by a control instruction issues to data lane 1 and the control lane, leaves data lane 2 empty, and reports consumed 2.
- R6: A third data instruction in a row is not taken: three data instructions report consumed 2.
- R7: A second control instruction is not taken in the same group: two control instructions report consumed 1.
- R8: An invalid window entry closes the group, and an invalid oldest entry gives consumed 0 and no valid lane after the edge.
- R9: While stall is high, consumed is 0 and every issue output keeps its value across the edge.
- R10: A lane that is not valid shows an all-zero word.
- R11: The control-lane status equals {data lane 2 status, data lane 1 status} as sampled at the previous clock edge, whether or not stall is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Downstream stall; blocks issue |
| win_vld | input | FW | Valid bit per window entry |
| win_ctl | input | FW | Class per entry: 0 data, 1 control |
| win_word | input | FW*IW | Instruction words, entry 0 lowest |
| consumed | output | 2 | Instructions taken this cycle (0 to 3) |
| d1_vld | output | 1 | Data lane 1 valid |
| d1_word | output | IW | Data lane 1 instruction |
| d2_vld | output | 1 | Data lane 2 valid |
| d2_word | output | IW | Data lane 2 instruction |
| c_vld | output | 1 | Control lane valid |
| c_word | output | IW | Control lane instruction |
| st1_in | input | SW | Status bits from data pipeline 1 |
| st2_in | input | SW | Status bits from data pipeline 2 |
| c_status | output | 2*SW | Status forwarded to the control lane |

## Verification
The bench builds the block with its defaults: a four-entry window, 32-bit words and four status bits per data pipeline. With four entries, every group-closing case is within reach. This covers a third data instruction, a second control instruction, a data instruction after a control one and an invalid entry, and each one still leaves one entry after the group it closes. Distinct word values per window position show which entry reached which lane.

// File: rtl/issue_aligner_pkg.sv
// Shared lane identifiers for the issue aligner.
// Assumes: lane order data 1, data 2, control is fixed.
package issue_aligner_pkg;
    typedef enum logic [1:0] {
        LANE_D1   = 2'd0,
        LANE_D2   = 2'd1,
        LANE_CTL  = 2'd2,
        LANE_DONE = 2'd3
    } lane_e;
endpackage

// File: rtl/aln_classify.sv
// Splits each window entry into a data mark and a control mark.
// Assumes: an invalid entry carries neither mark.
module aln_classify #(
    parameter int FW = 4
) (
    input  logic [FW-1:0] vld,
    input  logic [FW-1:0] ctl,
    output logic [FW-1:0] is_data,
    output logic [FW-1:0] is_ctrl
);
    for (genvar g = 0; g < FW; g++) begin : g_lane
        // Per-entry class decode.
        assign is_data[g] = vld[g] & ~ctl[g];
        assign is_ctrl[g] = vld[g] &  ctl[g];
    end
endmodule

// File: rtl/aln_pick.sv
// Forms one issue group from the classified window.
// Walks entries oldest first; the next free lane only moves forward,
// and the group closes at the first entry that has no lane left.
// Assumes: at most three lanes; count never exceeds 3.
module aln_pick
    import issue_aligner_pkg::*;
#(
    parameter int FW = 4,
    localparam int LW = (FW > 1) ? $clog2(FW) : 1
) (
    input  logic [FW-1:0] is_data,
    input  logic [FW-1:0] is_ctrl,
    output logic          d1_hit,
    output logic [LW-1:0] d1_idx,
    output logic          d2_hit,
    output logic [LW-1:0] d2_idx,
    output logic          c_hit,
    output logic [LW-1:0] c_idx,
    output logic [1:0]    take
);
    lane_e      nxt;
    logic       stop;

    // Group formation scan.
    always_comb begin
        nxt    = LANE_D1;
        stop   = 1'b0;
        take   = 2'd0;
        d1_hit = 1'b0;
        d2_hit = 1'b0;
        c_hit  = 1'b0;
        d1_idx = '0;
        d2_idx = '0;
        c_idx  = '0;
        for (int i = 0; i < FW; i++) begin
            if (!stop) begin
                if (is_data[i] && nxt == LANE_D1) begin
                    d1_hit = 1'b1;
                    d1_idx = LW'(i);
                    nxt    = LANE_D2;
                    take   = take + 2'd1;
                end else if (is_data[i] && nxt == LANE_D2) begin
                    d2_hit = 1'b1;
                    d2_idx = LW'(i);
                    nxt    = LANE_CTL;
                    take   = take + 2'd1;
                end else if (is_ctrl[i] && nxt != LANE_DONE) begin
                    c_hit  = 1'b1;
                    c_idx  = LW'(i);
                    nxt    = LANE_DONE;
                    take   = take + 2'd1;
                end else begin
                    stop   = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aln_status_fwd.sv
// Registers data-pipeline status bits toward the control lane.
// Assumes: status is independent of issue stall.
module aln_status_fwd #(
    parameter int SW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   st1_in,
    input  logic [SW-1:0]   st2_in,
    output logic [2*SW-1:0] c_status
);
    // One-cycle status transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) c_status <= '0;
        else        c_status <= {st2_in, st1_in};
    end
endmodule

// File: rtl/issue_aligner.sv
// Three-lane issue aligner top: classify, pick a group, register it.
// Assumes: window entry 0 is oldest; consumed is combinational so
// fetch can shift in the same cycle.
module issue_aligner #(
    parameter int FW = 4,
    parameter int IW = 32,
    parameter int SW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic [FW-1:0]   win_vld,
    input  logic [FW-1:0]   win_ctl,
    input  logic [FW*IW-1:0] win_word,
    output logic [1:0]      consumed,
    output logic            d1_vld,
    output logic [IW-1:0]   d1_word,
    output logic            d2_vld,
    output logic [IW-1:0]   d2_word,
    output logic            c_vld,
    output logic [IW-1:0]   c_word,
    input  logic [SW-1:0]   st1_in,
    input  logic [SW-1:0]   st2_in,
    output logic [2*SW-1:0] c_status
);
    localparam int LW = (FW > 1) ? $clog2(FW) : 1;

    logic [FW-1:0] is_data, is_ctrl;
    logic          d1_hit, d2_hit, c_hit;
    logic [LW-1:0] d1_idx, d2_idx, c_idx;
    logic [1:0]    take;
    logic [IW-1:0] d1_sel, d2_sel, c_sel;

    aln_classify #(.FW(FW)) u_cls (
        .vld(win_vld), .ctl(win_ctl), .is_data(is_data), .is_ctrl(is_ctrl)
    );

    aln_pick #(.FW(FW)) u_pick (
        .is_data(is_data), .is_ctrl(is_ctrl),
        .d1_hit(d1_hit), .d1_idx(d1_idx),
        .d2_hit(d2_hit), .d2_idx(d2_idx),
        .c_hit(c_hit),   .c_idx(c_idx),
        .take(take)
    );

    aln_status_fwd #(.SW(SW)) u_stat (
        .clk(clk), .rst_n(rst_n), .st1_in(st1_in), .st2_in(st2_in),
        .c_status(c_status)
    );

    // Word steering from chosen window entries; unused lanes read zero.
    always_comb begin
        d1_sel = d1_hit ? win_word[d1_idx*IW +: IW] : '0;
        d2_sel = d2_hit ? win_word[d2_idx*IW +: IW] : '0;
        c_sel  = c_hit  ? win_word[c_idx*IW +: IW]  : '0;
    end

    // Report taken count only when issue actually happens.
    assign consumed = stall ? 2'd0 : take;

    // Issue register; holds while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1_vld <= 1'b0; d1_word <= '0;
            d2_vld <= 1'b0; d2_word <= '0;
            c_vld  <= 1'b0; c_word  <= '0;
        end else if (!stall) begin
            d1_vld <= d1_hit; d1_word <= d1_sel;
            d2_vld <= d2_hit; d2_word <= d2_sel;
            c_vld  <= c_hit;  c_word  <= c_sel;
        end
    end
endmodule

// File: rtl/issue_aligner_chk.sv
// Property checker for the issue aligner, bound to every instance.
module issue_aligner_chk #(
    parameter int FW = 4,
    parameter int IW = 32,
    parameter int SW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic [FW-1:0]   win_vld,
    input logic [1:0]      consumed,
    input logic            d1_vld,
    input logic [IW-1:0]   d1_word,
    input logic            d2_vld,
    input logic [IW-1:0]   d2_word,
    input logic            c_vld,
    input logic [IW-1:0]   c_word,
    input logic [SW-1:0]   st1_in,
    input logic [SW-1:0]   st2_in,
    input logic [2*SW-1:0] c_status
);
    // R9
    stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> consumed == 2'd0);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable({d1_vld, d1_word, d2_vld, d2_word, c_vld, c_word}));
    // R8
    empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_vld[0] && !stall) |=> !(d1_vld || d2_vld || c_vld));
    // R2
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> $countones({d1_vld, d2_vld, c_vld}) == int'($past(consumed)));
    // R3
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d2_vld |-> d1_vld);
    // R10
    idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!d1_vld -> d1_word == '0) && (!d2_vld -> d2_word == '0) &&
        (!c_vld -> c_word == '0));
    // R11
    status_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> c_status == $past({st2_in, st1_in}));
endmodule

bind issue_aligner issue_aligner_chk #(.FW(FW), .IW(IW), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .win_vld(win_vld),
    .consumed(consumed),
    .d1_vld(d1_vld), .d1_word(d1_word), .d2_vld(d2_vld), .d2_word(d2_word),
    .c_vld(c_vld), .c_word(c_word),
    .st1_in(st1_in), .st2_in(st2_in), .c_status(c_status)
);

// File: tb/issue_aligner_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module issue_aligner_bench;
    localparam int FW = 4, IW = 32, SW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stall = 1'b0;
    logic [FW-1:0]   win_vld = '0, win_ctl = '0;
    logic [FW*IW-1:0] win_word = '0;
    logic [1:0]      consumed;
    logic            d1_vld, d2_vld, c_vld;
    logic [IW-1:0]   d1_word, d2_word, c_word;
    logic [SW-1:0]   st1_in = '0, st2_in = '0;
    logic [2*SW-1:0] c_status;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    issue_aligner #(.FW(FW), .IW(IW), .SW(SW)) u_issue_aligner (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .win_vld(win_vld), .win_ctl(win_ctl), .win_word(win_word),
        .consumed(consumed),
        .d1_vld(d1_vld), .d1_word(d1_word), .d2_vld(d2_vld), .d2_word(d2_word),
        .c_vld(c_vld), .c_word(c_word),
        .st1_in(st1_in), .st2_in(st2_in), .c_status(c_status)
    );

    function automatic logic [IW-1:0] wd(int i);
        return 32'hA5C0_0000 + 32'(i * 17 + 1);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a window at a negedge, check consumed, then lanes after the edge.
    task automatic run(string req, logic [FW-1:0] v, logic [FW-1:0] c,
                       logic [1:0] exp_cons, logic [2:0] exp_vld,
                       logic [IW-1:0] e1, logic [IW-1:0] e2, logic [IW-1:0] ec);
        @(negedge clk);
        win_vld = v; win_ctl = c;
        for (int i = 0; i < FW; i++) win_word[i*IW +: IW] = wd(i);
        #1 chk({req, " consumed"}, 64'(consumed), 64'(exp_cons));
        @(negedge clk);
        chk({req, " valids"}, 64'({d1_vld, d2_vld, c_vld}), 64'(exp_vld));
        chk({req, " words"}, {d1_word, d2_word}, {e1, e2});
        chk({req, " ctl word"}, 64'(c_word), 64'(ec));
    endtask

    task automatic t_reset;
        chk("R1 reset lanes", 64'({d1_vld, d2_vld, c_vld}), 64'd0);
        chk("R1 reset words", {d1_word, d2_word}, 64'd0);
        chk("R1 reset status", 64'(c_status), 64'd0);
    endtask

    task automatic t_full;     // R2, R3
        run("R2 d,d,c", 4'b1111, 4'b0100, 2'd3, 3'b111, wd(0), wd(1), wd(2));
    endtask
    task automatic t_ctrl_first; // R4: control closes group
        run("R4 c,d", 4'b1111, 4'b0001, 2'd1, 3'b001, '0, '0, wd(0));
    endtask
    task automatic t_gap;      // R5, R10
        run("R5 d,c", 4'b1111, 4'b1010, 2'd2, 3'b101, wd(0), '0, wd(1));
    endtask
    task automatic t_three_data; // R6, R3
        run("R6 d,d,d", 4'b1111, 4'b0000, 2'd2, 3'b110, wd(0), wd(1), '0);
    endtask
    task automatic t_two_ctrl; // R7
        run("R7 c,c", 4'b1111, 4'b0011, 2'd1, 3'b001, '0, '0, wd(0));
    endtask
    task automatic t_invalid;  // R8
        run("R8 head invalid", 4'b1110, 4'b0000, 2'd0, 3'b000, '0, '0, '0);
        run("R8 mid invalid", 4'b1101, 4'b0000, 2'd1, 3'b100, wd(0), '0, '0);
    endtask

    task automatic t_stall;    // R9
        run("R9 setup", 4'b0011, 4'b0010, 2'd2, 3'b101, wd(0), '0, wd(1));
        @(negedge clk);
        stall = 1'b1; win_vld = 4'b1111; win_ctl = 4'b0000;
        #1 chk("R9 stalled consumed", 64'(consumed), 64'd0);
        @(negedge clk);
        chk("R9 held valids", 64'({d1_vld, d2_vld, c_vld}), 64'b101);
        chk("R9 held words", {d1_word, c_word}, {wd(0), wd(1)});
        stall = 1'b0;
    endtask

    task automatic t_status;   // R11
        @(negedge clk);
        stall = 1'b1; st1_in = 4'h3; st2_in = 4'hC;
        @(negedge clk);
        chk("R11 status under stall", 64'(c_status), 64'hC3);
        stall = 1'b0; st1_in = 4'h9; st2_in = 4'h5;
        @(negedge clk);
        chk("R11 status", 64'(c_status), 64'h59);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_full; t_ctrl_first; t_gap; t_three_data; t_two_ctrl;
        t_invalid; t_stall; t_status;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule